// File: doc/BRIEF.md
# Store Buffer with Read Forwarding

This block is a small queue that sits between a write-through cache and a slower main memory. Every store that the processor writes into the cache is pushed into the queue in the same cycle. The memory side takes the stores out strictly in arrival order, through a valid/acknowledge handshake. Because the queue can hold the only current copy of a location, a read miss must be checked against it before it goes to memory. Every buffered entry is compared with the read address in parallel. If one matches, the youngest matching entry supplies the data. If none matches, the read is released to memory at once.

A dirty line that a read miss evicts is pushed on the ordinary write port, and the refill read is released in the same cycle without waiting for the write-back. A policy input selects a conservative alternative. In that mode there is no forwarding, and a read is released only once the queue has fully drained.

Top module: `wbuf_fwd`

## Requirements
- R1: After a synchronous active-high reset, `empty` is 1, `full` is 0, `wr_ready` is 1 and `mem_valid` is 0.
- R2: A store is accepted on a clock edge where `wr_valid` and `wr_ready` are both 1. After DEPTH (default 4) accepted stores with no drain, `full` is 1 and `wr_ready` is 0.
- R3: A store offered while `full` is 1 is refused and does not overwrite or drop any entry. The buffer stays full, and the drain later shows only the original entries.
- R4: While the buffer is non-empty, `mem_valid` is 1 and `mem_addr`/`mem_data` show the oldest entry. That entry stays on the port unchanged until `mem_ack` is 1, and the entry is removed on that edge. Entries leave in arrival order.
- R5: A store accepted on the same edge as a drain leaves the occupancy unchanged, and the new store goes behind all older entries.
- R6: In forwarding policy (`rd_policy` = 0), a lookup (`rd_req` = 1) whose address equals a buffered entry's address gives `rd_hit` = 1, `rd_go` = 0, and that entry's data on `rd_data`. Whenever `rd_hit` is 0, `rd_data` is 0.
- R7: When several buffered entries hold the lookup address, `rd_data` comes from the most recently accepted of them.
- R8: In forwarding policy, a lookup that matches no buffered entry gives `rd_go` = 1 and `rd_hit` = 0, even when the buffer is non-empty. A store pushed in the same cycle, such as an evicted dirty line, is not yet part of the lookup and does not delay `rd_go`.
- R9: In drain-first policy (`rd_policy` = 1), `rd_hit` is always 0, and `rd_go` is 1 for a lookup only when the buffer is empty.
- R10: With `rd_req` = 0, `rd_hit` and `rd_go` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Store offered by the processor side |
| wr_addr | input | 16 | Store address |
| wr_data | input | 32 | Store data |
| wr_ready | output | 1 | Buffer can accept a store |
| rd_req | input | 1 | Read miss lookup request |
| rd_addr | input | 16 | Lookup address |
| rd_policy | input | 1 | 0 = forward from buffer, 1 = wait for empty buffer |
| rd_hit | output | 1 | Lookup served from the buffer |
| rd_data | output | 32 | Forwarded data (0 when no hit) |
| rd_go | output | 1 | Read may proceed to main memory |
| mem_valid | output | 1 | Oldest entry is offered to memory |
| mem_addr | output | 16 | Address of the oldest entry |
| mem_data | output | 32 | Data of the oldest entry |
| mem_ack | input | 1 | Memory takes the offered entry |
| full | output | 1 | All entries occupied |
| empty | output | 1 | No entries occupied |

## Verification
The bench fills the buffer with two stores to the same address and reads that address back. A design that scanned from the oldest slot would return the stale value instead of the youngest one. It offers a store to a full buffer, and then drains it. A design that overwrote the tail or advanced a pointer would show the refused address or a lost entry in the drain order. It pushes and drains in the same edge, and it counts the acknowledges needed to empty the buffer, which exposes a wrong occupancy update. It also issues a lookup together with an eviction push, and it runs lookups under the drain-first policy. Here a design that waited for the write-back, or that forwarded in the conservative mode, would show the wrong `rd_go` or `rd_hit`.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;

    localparam int unsigned WB_ADDR_W = 16;
    localparam int unsigned WB_DATA_W = 32;

    typedef logic [WB_ADDR_W-1:0] waddr_t;
    typedef logic [WB_DATA_W-1:0] wdata_t;

    typedef struct packed {
        waddr_t addr;
        wdata_t data;
    } wb_ent_t;

    typedef enum logic {
        RD_FORWARD     = 1'b0,
        RD_DRAIN_FIRST = 1'b1
    } rd_policy_e;

    function automatic logic addr_eq(input waddr_t a, input waddr_t b);
        return a == b;
    endfunction

endpackage

// File: rtl/wbuf_queue.sv
module wbuf_queue
    import wbuf_pkg::*;
#(
    parameter int unsigned DEPTH = 4,
    localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CW = PW + 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 push,
    input  wb_ent_t              push_ent,
    input  logic                 pop,
    output wb_ent_t [DEPTH-1:0]  slots,
    output logic [PW-1:0]        head,
    output logic [CW-1:0]        cnt
);

    logic [PW-1:0] head_q, tail_q;
    logic [CW-1:0] cnt_q;
    wb_ent_t [DEPTH-1:0] slots_q;

    function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q <= '0;
            tail_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (push) tail_q <= ptr_next(tail_q);
            if (pop)  head_q <= ptr_next(head_q);
            case ({push, pop})
                2'b10:   cnt_q <= cnt_q + CW'(1);
                2'b01:   cnt_q <= cnt_q - CW'(1);
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (push) slots_q[tail_q] <= push_ent;
    end

    assign slots = slots_q;
    assign head  = head_q;
    assign cnt   = cnt_q;

    // R2
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CW'(DEPTH));

    // R4
    pop_nonempty_chk: assert property (@(posedge clk) disable iff (rst)
        pop |-> cnt_q != '0);

    // R3
    push_room_chk: assert property (@(posedge clk) disable iff (rst)
        (push && !pop) |-> cnt_q < CW'(DEPTH));

endmodule

// File: rtl/wbuf_cam.sv
module wbuf_cam
    import wbuf_pkg::*;
#(
    parameter int unsigned DEPTH = 4,
    localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CW = PW + 1
) (
    input  wb_ent_t [DEPTH-1:0] slots,
    input  logic [PW-1:0]       head,
    input  logic [CW-1:0]       cnt,
    input  waddr_t              look_addr,
    output logic                hit,
    output wdata_t              hit_data
);

    logic [PW-1:0]    age_idx [DEPTH];
    logic [DEPTH-1:0] match;

    // age g = 0 is the oldest entry; larger g is younger
    for (genvar g = 0; g < DEPTH; g++) begin : g_age
        logic [PW:0] raw;
        assign raw = {1'b0, head} + (PW+1)'(g);
        assign age_idx[g] = (raw >= (PW+1)'(DEPTH)) ? PW'(raw - (PW+1)'(DEPTH))
                                                     : PW'(raw);
        assign match[g] = (CW'(g) < cnt) && addr_eq(slots[age_idx[g]].addr, look_addr);
    end

    always_comb begin
        hit      = 1'b0;
        hit_data = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (match[i]) begin
                hit      = 1'b1;
                hit_data = slots[age_idx[i]].data;
            end
        end
    end

endmodule

// File: rtl/wbuf_fwd.sv
module wbuf_fwd
    import wbuf_pkg::*;
#(
    parameter int unsigned DEPTH = 4,
    localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CW = PW + 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_valid,
    input  logic [WB_ADDR_W-1:0] wr_addr,
    input  logic [WB_DATA_W-1:0] wr_data,
    output logic                 wr_ready,
    input  logic                 rd_req,
    input  logic [WB_ADDR_W-1:0] rd_addr,
    input  logic                 rd_policy,
    output logic                 rd_hit,
    output logic [WB_DATA_W-1:0] rd_data,
    output logic                 rd_go,
    output logic                 mem_valid,
    output logic [WB_ADDR_W-1:0] mem_addr,
    output logic [WB_DATA_W-1:0] mem_data,
    input  logic                 mem_ack,
    output logic                 full,
    output logic                 empty
);

    wb_ent_t [DEPTH-1:0] slots;
    logic [PW-1:0]       head;
    logic [CW-1:0]       cnt;
    logic                push, pop;
    wb_ent_t             push_ent;
    logic                cam_hit;
    wdata_t              cam_data;
    rd_policy_e          policy;
    logic                fwd_en;

    assign full     = (cnt == CW'(DEPTH));
    assign empty    = (cnt == '0);
    assign wr_ready = !full;
    assign push     = wr_valid && wr_ready;
    assign push_ent = '{addr: wr_addr, data: wr_data};
    assign mem_valid = !empty;
    assign pop      = mem_valid && mem_ack;
    assign mem_addr = slots[head].addr;
    assign mem_data = slots[head].data;

    wbuf_queue #(.DEPTH(DEPTH)) u_queue (
        .clk      (clk),
        .rst      (rst),
        .push     (push),
        .push_ent (push_ent),
        .pop      (pop),
        .slots    (slots),
        .head     (head),
        .cnt      (cnt)
    );

    wbuf_cam #(.DEPTH(DEPTH)) u_cam (
        .slots     (slots),
        .head      (head),
        .cnt       (cnt),
        .look_addr (rd_addr),
        .hit       (cam_hit),
        .hit_data  (cam_data)
    );

    assign policy  = rd_policy_e'(rd_policy);
    assign fwd_en  = (policy == RD_FORWARD);
    assign rd_hit  = rd_req && fwd_en && cam_hit;
    assign rd_data = rd_hit ? cam_data : '0;
    assign rd_go   = rd_req && (fwd_en ? !cam_hit : empty);

    // R9
    drain_first_go_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_policy && rd_go) |-> empty);

    // R6
    hit_go_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(rd_hit && rd_go));

    // R4
    head_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_ack) |=> mem_valid && $stable(mem_addr) && $stable(mem_data));

    // R3
    full_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (full && !mem_ack) |=> full);

    // R5
    occ_steady_chk: assert property (@(posedge clk) disable iff (rst)
        (push && pop) |=> $stable(full) && $stable(empty));

endmodule

// File: tb/sim_wbuf_fwd.sv
module sim_wbuf_fwd;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_valid;
    logic [15:0] wr_addr;
    logic [31:0] wr_data;
    logic        wr_ready;
    logic        rd_req;
    logic [15:0] rd_addr;
    logic        rd_policy;
    logic        rd_hit;
    logic [31:0] rd_data;
    logic        rd_go;
    logic        mem_valid;
    logic [15:0] mem_addr;
    logic [31:0] mem_data;
    logic        mem_ack;
    logic        full;
    logic        empty;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wbuf_fwd #(.DEPTH(4)) u0 (
        .clk(clk), .rst(rst),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ready(wr_ready),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_policy(rd_policy),
        .rd_hit(rd_hit), .rd_data(rd_data), .rd_go(rd_go),
        .mem_valid(mem_valid), .mem_addr(mem_addr), .mem_data(mem_data), .mem_ack(mem_ack),
        .full(full), .empty(empty)
    );

    typedef struct packed {
        logic        req;
        logic        pol;
        logic [15:0] addr;
        logic        hit;
        logic [31:0] data;
        logic        go;
    } look_t;

    localparam int NLOOK = 7;
    localparam look_t LOOKS [NLOOK] = '{
        '{1'b1, 1'b0, 16'h0010, 1'b1, 32'hCCCC0003, 1'b0},  // R7 youngest of two
        '{1'b1, 1'b0, 16'h0020, 1'b1, 32'hBBBB0002, 1'b0},  // R6
        '{1'b1, 1'b0, 16'h0040, 1'b1, 32'hDDDD0004, 1'b0},  // R6
        '{1'b1, 1'b0, 16'h0030, 1'b0, 32'h00000000, 1'b1},  // R8 miss, non-empty
        '{1'b1, 1'b1, 16'h0010, 1'b0, 32'h00000000, 1'b0},  // R9
        '{1'b1, 1'b1, 16'h0030, 1'b0, 32'h00000000, 1'b0},  // R9
        '{1'b0, 1'b0, 16'h0010, 1'b0, 32'h00000000, 1'b0}   // R10
    };
    localparam string LOOK_TAG [NLOOK] = '{"R7", "R6", "R6", "R8", "R9", "R9", "R10"};

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic push(input logic [15:0] a, input logic [31:0] d);
        wr_valid = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic drain(input string req, input logic [15:0] a, input logic [31:0] d);
        #1;
        chk(req, {31'd0, mem_valid}, 32'd1);
        chk(req, {16'd0, mem_addr}, {16'd0, a});
        chk(req, mem_data, d);
        mem_ack = 1'b1;
        @(negedge clk);
        mem_ack = 1'b0;
    endtask

    task automatic look(input string req, input logic pol, input logic [15:0] a,
                        input logic hit, input logic [31:0] d, input logic go);
        rd_req = 1'b1; rd_policy = pol; rd_addr = a;
        #1;
        chk(req, {31'd0, rd_hit}, {31'd0, hit});
        chk(req, rd_data, d);
        chk(req, {31'd0, rd_go}, {31'd0, go});
        @(negedge clk);
        rd_req = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; wr_valid = 0; wr_addr = 0; wr_data = 0;
        rd_req = 0; rd_addr = 0; rd_policy = 0; mem_ack = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1
        chk("R1", {31'd0, empty}, 32'd1);
        chk("R1", {31'd0, full}, 32'd0);
        chk("R1", {31'd0, wr_ready}, 32'd1);
        chk("R1", {31'd0, mem_valid}, 32'd0);
        @(negedge clk);

        // R2 fill to depth, two stores to 0x0010
        push(16'h0010, 32'hAAAA0001);
        push(16'h0020, 32'hBBBB0002);
        push(16'h0010, 32'hCCCC0003);
        #1;
        chk("R2", {31'd0, full}, 32'd0);
        @(negedge clk);
        push(16'h0040, 32'hDDDD0004);
        #1;
        chk("R2", {31'd0, full}, 32'd1);
        chk("R2", {31'd0, wr_ready}, 32'd0);
        @(negedge clk);

        // R3 offer a store while full
        push(16'h0050, 32'hEEEE0005);
        #1;
        chk("R3", {31'd0, full}, 32'd1);
        @(negedge clk);

        // table of lookups against the full buffer
        for (int k = 0; k < NLOOK; k++) begin
            rd_req = LOOKS[k].req; rd_policy = LOOKS[k].pol; rd_addr = LOOKS[k].addr;
            #1;
            chk(LOOK_TAG[k], {31'd0, rd_hit}, {31'd0, LOOKS[k].hit});
            chk(LOOK_TAG[k], rd_data, LOOKS[k].data);
            chk(LOOK_TAG[k], {31'd0, rd_go}, {31'd0, LOOKS[k].go});
            @(negedge clk);
            rd_req = 1'b0; rd_policy = 1'b0;
        end

        // R4 head holds while not acknowledged
        #1;
        chk("R4", {16'd0, mem_addr}, 32'h0010);
        @(negedge clk);
        drain("R4", 16'h0010, 32'hAAAA0001);
        drain("R4", 16'h0020, 32'hBBBB0002);
        drain("R4", 16'h0010, 32'hCCCC0003);
        drain("R3", 16'h0040, 32'hDDDD0004);
        #1;
        chk("R3", {31'd0, empty}, 32'd1);
        @(negedge clk);

        // R9 drain-first releases once empty; R8 drained data no longer hits
        look("R9", 1'b1, 16'h0010, 1'b0, 32'h0, 1'b1);
        look("R8", 1'b0, 16'h0010, 1'b0, 32'h0, 1'b1);

        // R5 push and drain on one edge
        push(16'h0100, 32'h00000001);
        push(16'h0200, 32'h00000002);
        wr_valid = 1'b1; wr_addr = 16'h0300; wr_data = 32'h00000003; mem_ack = 1'b1;
        #1;
        chk("R5", {16'd0, mem_addr}, 32'h0100);
        @(negedge clk);
        wr_valid = 1'b0; mem_ack = 1'b0;
        drain("R5", 16'h0200, 32'h00000002);
        #1;
        chk("R5", {31'd0, empty}, 32'd0);
        drain("R5", 16'h0300, 32'h00000003);
        #1;
        chk("R5", {31'd0, empty}, 32'd1);
        @(negedge clk);

        // R8 eviction parked while refill read is released at once
        push(16'h0900, 32'h00000009);
        wr_valid = 1'b1; wr_addr = 16'h0700; wr_data = 32'h77770007;
        rd_req = 1'b1; rd_policy = 1'b0; rd_addr = 16'h0700;
        #1;
        chk("R8", {31'd0, rd_go}, 32'd1);
        chk("R8", {31'd0, rd_hit}, 32'd0);
        @(negedge clk);
        wr_valid = 1'b0;
        #1;
        chk("R6", {31'd0, rd_hit}, 32'd1);
        chk("R6", rd_data, 32'h77770007);
        @(negedge clk);
        rd_req = 1'b0;
        drain("R4", 16'h0900, 32'h00000009);
        drain("R4", 16'h0700, 32'h77770007);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule